// File: doc/BRIEF.md
# Segmented Address Protection Unit

This block turns a logical address, given as a segment number plus an offset, into a physical address. It uses a small table of segments. Each table entry holds a base address, an absolute upper physical limit, three access-permission bits and a valid bit.

Every request also carries an access type: read, write or instruction fetch. The block adds the offset to the selected base and checks the sum against the entry's limit. It then checks the access type against the entry's permissions. One cycle later it returns either the physical address or a fault with a cause code.

A privileged write port loads or invalidates one entry per cycle. The same physical region can be described by several entries, each with different rights. Each request is judged only by the entry it names.

Top module: `seg_guard`

## Requirements
- R1: After reset every table entry is invalid, and `rsp_valid` is low until a request is made.
- R2: For an allowed access, `rsp_addr` equals the base of the named entry plus `req_off`.
- R3: The limit is an absolute physical address and is inclusive. A sum equal to the limit is allowed. A sum above it faults with cause 2.
- R4: The sum is formed with a carry bit. A sum that overflows 16 bits faults with cause 2, even when the truncated value lies below the limit.
- R5: Permission bits are bit 0 read, bit 1 write and bit 2 execute. `req_type` is coded 2'b00 read, 2'b01 write and 2'b10 execute. A clear bit for the requested type faults with cause 3, and type 2'b11 always faults with cause 3.
- R6: A request that names an invalid entry faults with cause 1.
- R7: When several checks fail, the reported cause follows the priority invalid (1), then limit (2), then permission (3).
- R8: Cause 0 means no fault. Whenever `rsp_fault` is high, `rsp_addr` is zero, and `rsp_fault` is high exactly when the cause is non-zero.
- R9: `rsp_valid` rises exactly one cycle after `req_valid`. With no request, the response outputs are all zero.
- R10: A table write is visible from the next cycle. A lookup in the same cycle as a write to the same entry sees the old contents.
- R11: Two entries that map the same region with different permissions are checked independently, each against its own permissions.
- R12: A table write with `wr_valid` low invalidates the entry. Later lookups of that entry fault with cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 3 | Segment number of the request |
| req_off | input | 16 | Offset within the segment |
| req_type | input | 2 | Access type: 00 read, 01 write, 10 execute |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | 3 | Entry being written |
| wr_valid | input | 1 | Valid bit written into the entry |
| wr_base | input | 16 | Base address written into the entry |
| wr_limit | input | 16 | Inclusive upper physical limit |
| wr_perm | input | 3 | Permission mask {exec, write, read} |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 limit, 3 permission |
| rsp_addr | output | 16 | Physical address, zero on a fault |

## Verification
The hardest cases to reach are those in which several checks fail together. An example is an unmapped entry with an offset that would also overflow, or an entry with no permissions whose sum also passes the limit. The vector table builds such entries on purpose, so that the priority order decides the cause.

The same-cycle case is reached with a directed step. A write and a lookup of the same entry are presented on one falling edge. The response must still show the old mapping, and the next lookup must show the new one.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int SEG_W  = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        req_type,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic [2:0]        wr_perm,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int NSEG = 1 << SEG_W;
  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_INV  = 2'd1;
  localparam logic [1:0] C_LIM  = 2'd2;
  localparam logic [1:0] C_PERM = 2'd3;

  logic [ADDR_W-1:0] base_q  [NSEG];
  logic [ADDR_W-1:0] limit_q [NSEG];
  logic [2:0]        perm_q  [NSEG];
  logic [NSEG-1:0]   vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      vld_q <= '0;
    else if (wr_en)
      vld_q[wr_seg] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_q[wr_seg]  <= wr_base;
      limit_q[wr_seg] <= wr_limit;
      perm_q[wr_seg]  <= wr_perm;
    end
  end

  logic [ADDR_W:0]   sum;
  logic              over;
  logic              allowed;
  logic [1:0]        cause_d;

  assign sum  = {1'b0, base_q[req_seg]} + {1'b0, req_off};
  assign over = sum[ADDR_W] || (sum[ADDR_W-1:0] > limit_q[req_seg]);

  always_comb begin
    case (req_type)
      2'b00:   allowed = perm_q[req_seg][0];
      2'b01:   allowed = perm_q[req_seg][1];
      2'b10:   allowed = perm_q[req_seg][2];
      default: allowed = 1'b0;
    endcase
    if (!vld_q[req_seg]) cause_d = C_INV;
    else if (over)       cause_d = C_LIM;
    else if (!allowed)   cause_d = C_PERM;
    else                 cause_d = C_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_NONE;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && (cause_d != C_NONE);
      rsp_cause <= req_valid ? cause_d : C_NONE;
      rsp_addr  <= (req_valid && cause_d == C_NONE) ? sum[ADDR_W-1:0] : '0;
    end
  end

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_addr == '0));
  p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_addr == '0 && rsp_valid));
  p_invalid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vld_q[req_seg]) |=> (rsp_cause == C_INV));
  p_write_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_seg)] == $past(wr_valid)));
  p_carry_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vld_q[req_seg] && sum[ADDR_W]) |=> (rsp_cause == C_LIM));
endmodule

// File: tb/seg_guard_tb.sv
module seg_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_type = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_seg = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_base = '0;
  logic [15:0] wr_limit = '0;
  logic [2:0]  wr_perm = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [15:0] rsp_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .req_type(req_type), .wr_en(wr_en), .wr_seg(wr_seg),
    .wr_valid(wr_valid), .wr_base(wr_base), .wr_limit(wr_limit),
    .wr_perm(wr_perm), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_addr(rsp_addr)
  );

  // {seg, off, type, cause, addr}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {3'd0, 16'h0000, 2'b00, 2'd0, 16'h1000},
    {3'd0, 16'h0FFF, 2'b01, 2'd0, 16'h1FFF},
    {3'd0, 16'h1000, 2'b00, 2'd2, 16'h0000},
    {3'd1, 16'h0010, 2'b01, 2'd0, 16'h2010},
    {3'd2, 16'h0010, 2'b01, 2'd3, 16'h0000},
    {3'd2, 16'h0010, 2'b00, 2'd0, 16'h2010},
    {3'd3, 16'h0FFF, 2'b10, 2'd0, 16'hFFFF},
    {3'd3, 16'h1000, 2'b10, 2'd2, 16'h0000},
    {3'd3, 16'h0005, 2'b00, 2'd3, 16'h0000},
    {3'd1, 16'h0005, 2'b10, 2'd3, 16'h0000},
    {3'd1, 16'h0001, 2'b11, 2'd3, 16'h0000},
    {3'd5, 16'h0000, 2'b00, 2'd1, 16'h0000},
    {3'd5, 16'hFFFF, 2'b11, 2'd1, 16'h0000},
    {3'd4, 16'h0200, 2'b01, 2'd2, 16'h0000},
    {3'd4, 16'h0050, 2'b00, 2'd3, 16'h0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic v, input logic [15:0] b,
                      input logic [15:0] l, input logic [2:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = s; wr_valid = v; wr_base = b; wr_limit = l; wr_perm = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [2:0] s, input logic [15:0] o, input logic [1:0] t,
                        input logic [1:0] ec, input logic [15:0] ea, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_type = t;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, tag, {31'd0, rsp_valid}, 32'd1);
    check(rsp_cause == ec && rsp_fault == (ec != 2'd0), tag, {29'd0, rsp_fault, rsp_cause}, {29'd0, ec != 2'd0, ec});
    check(rsp_addr == ea, tag, {16'd0, rsp_addr}, {16'd0, ea});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R9: idle after reset
    check(rsp_valid == 1'b0 && rsp_fault == 1'b0 && rsp_addr == 16'h0, "R1 idle", {15'd0, rsp_valid, rsp_addr}, 32'd0);
    // R1: every entry invalid after reset
    for (int s = 0; s < 8; s++) lookup(s[2:0], 16'h0, 2'b00, 2'd1, 16'h0, "R1 reset invalid");

    load(3'd0, 1'b1, 16'h1000, 16'h1FFF, 3'b111);
    load(3'd1, 1'b1, 16'h2000, 16'h27FF, 3'b011);
    load(3'd2, 1'b1, 16'h2000, 16'h27FF, 3'b001);
    load(3'd3, 1'b1, 16'hF000, 16'hFFFF, 3'b100);
    load(3'd4, 1'b1, 16'h0100, 16'h01FF, 3'b000);

    // R2 R3 R4 R5 R6 R7 R8 R11 vectors
    for (int i = 0; i < NV; i++)
      lookup(VEC[i][38:36], VEC[i][35:20], VEC[i][19:18], VEC[i][17:16], VEC[i][15:0], "R2-R11 vector");

    // R9: no request, no response
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_cause == 2'd0, "R9 quiet", {29'd0, rsp_valid, rsp_cause}, 32'd0);

    // R10: same-cycle write and lookup sees old mapping
    @(negedge clk);
    wr_en = 1'b1; wr_seg = 3'd1; wr_valid = 1'b1; wr_base = 16'h3000; wr_limit = 16'h30FF; wr_perm = 3'b011;
    req_valid = 1'b1; req_seg = 3'd1; req_off = 16'h0004; req_type = 2'b00;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check(rsp_cause == 2'd0 && rsp_addr == 16'h2004, "R10 old contents", {14'd0, rsp_cause, rsp_addr}, {14'd0, 2'd0, 16'h2004});
    lookup(3'd1, 16'h0004, 2'b00, 2'd0, 16'h3004, "R10 new contents");
    // R11: alias entry untouched by rewrite of its partner
    lookup(3'd2, 16'h0004, 2'b00, 2'd0, 16'h2004, "R11 alias independent");

    // R12: invalidate
    load(3'd0, 1'b0, 16'h1000, 16'h1FFF, 3'b111);
    lookup(3'd0, 16'h0000, 2'b00, 2'd1, 16'h0000, "R12 invalidated");

    // R1: reset clears valid bits again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup(3'd3, 16'h0001, 2'b10, 2'd1, 16'h0000, "R1 reset reclears");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule